// File: doc/BRIEF.md
# Power-Fail and Pushbutton Reset Sequencer

This block supervises the reset line of a chip that shares one open-drain pad between its reset output and a pushbutton. When the power-good input is false, it pulls the line low and blocks the register interface. When power returns, it keeps both asserted for a programmable number of millisecond ticks. Ticks are counted only while the oscillator is running, so a restart after the oscillator was stopped lengthens the hold by the startup time.

While nothing is in progress, the sequencer watches the synchronized pad level. A falling edge means the button was pressed. The block then pulls the line low itself for one debounce period and releases it. It waits until the synchronizer has settled and reads the pad again. A high level means the press is over, and the block goes back to monitoring. A low level means the button is still held, so the block waits for release and then drives the line low for a second debounce period. Any edge on the pad while the block drives it is ignored. The debounce and hold lengths are parameters counted in tick enables.

Top module: `rstseq_top`

## Requirements
- R1: While `pwr_good` is 0, `line_drive_low` and `access_block` are 1 from the next clock onward. The reset state is the power-fail state, with both outputs at 1.
- R2: After `pwr_good` rises, both outputs stay at 1 until HOLD_TICKS tick pulses have been counted. Both then fall to 0.
- R3: Tick pulses that arrive while `osc_run` is 0 are not counted toward the power-up hold.
- R4: During monitoring, a 1-to-0 transition of `line_in` (1 = pad high) makes `line_drive_low` rise within SYNC_STAGES+2 cycles. It stays at 1 for DEB_TICKS tick pulses.
- R5: After the first debounce the line is released. If the pad reads high once the synchronizer has settled, the block returns to monitoring, drives nothing more and clears `access_block`.
- R6: If the pad still reads low after the first debounce, the block waits with the line released. On the pad's return to high, it drives the line low again for DEB_TICKS ticks, then returns to monitoring with `access_block` at 0.
- R7: `access_block` is 1 whenever `line_drive_low` is 1, and also while the block waits for the button to be released.
- R8: Loss of power during any pushbutton phase forces the power-fail state. Recovery then takes the full power-up hold.
- R9: Edges on `line_in` that occur while the block drives the line do not start a pushbutton sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Synchronized supply-valid indication |
| osc_run | input | 1 | 1 when the oscillator is running |
| tick | input | 1 | One-cycle millisecond tick enable |
| line_in | input | 1 | Sampled pad level, 1 = high |
| line_drive_low | output | 1 | 1 pulls the open-drain pad low |
| access_block | output | 1 | 1 inhibits register reads and writes |

## Verification
The hardest situation to reach is the choice made at the end of the first debounce. There the pad level is hidden by the block's own drive and passes through the synchronizer late. The stimulus table varies the press length on both sides of the debounce period, so some presses end while the block still drives the line and others outlast it. A second directed case removes power in the middle of a press. A third toggles the button during the power-up hold, when every edge must be ignored.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PF_ACTIVE,
        SQ_PF_HOLD,
        SQ_PB_DEBOUNCE1,
        SQ_PB_WAIT_RELEASE,
        SQ_PB_DEBOUNCE2
    } seq_state_e;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int    STAGES    = 2,
    parameter logic  RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q[0] <= RESET_VAL;
                else        sr_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q[i] <= RESET_VAL;
                else        sr_q[i] <= sr_q[i-1];
            end
        end
    end

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    assign done = (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clr)            cnt_q <= '0;
        else if (step && !done)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_TICKS  = 180,
    parameter int DEB_TICKS   = 180
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic osc_run,
    input  logic tick,
    input  logic line_in,
    output logic line_drive_low,
    output logic access_block
);
    localparam int MAX_TICKS = (HOLD_TICKS > DEB_TICKS) ? HOLD_TICKS : DEB_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam int SETTLE    = SYNC_STAGES + 1;
    localparam int SET_W     = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(HOLD_TICKS);
    localparam logic [CNT_W-1:0] DEB_LIM  = CNT_W'(DEB_TICKS);
    localparam logic [SET_W-1:0] SET_LIM  = SET_W'(SETTLE);

    typedef struct packed {
        seq_state_e       st;
        logic             prev;
        logic [SET_W-1:0] settle;
        logic             held;
    } seq_regs_t;

    seq_regs_t        r_q, r_d;
    logic             line_s;
    logic             t_clr, t_step, t_done;
    logic [CNT_W-1:0] t_limit;

    rstseq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
    );

    rstseq_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(t_clr), .step(t_step),
        .limit(t_limit), .done(t_done)
    );

    always_comb begin
        r_d     = r_q;
        t_step  = 1'b0;
        t_limit = DEB_LIM;
        unique case (r_q.st)
            SQ_PF_ACTIVE: begin
                if (pwr_good) r_d.st = SQ_PF_HOLD;
            end
            SQ_PF_HOLD: begin
                t_limit = HOLD_LIM;
                t_step  = tick && osc_run;
                if (t_done) r_d.st = SQ_IDLE;
            end
            SQ_IDLE: begin
                if (r_q.prev && !line_s) r_d.st = SQ_PB_DEBOUNCE1;
            end
            SQ_PB_DEBOUNCE1: begin
                t_step = tick;
                if (t_done) begin
                    r_d.st     = SQ_PB_WAIT_RELEASE;
                    r_d.settle = '0;
                    r_d.held   = 1'b0;
                end
            end
            SQ_PB_WAIT_RELEASE: begin
                if (r_q.settle < SET_LIM) begin
                    r_d.settle = r_q.settle + 1'b1;
                end else if (line_s) begin
                    r_d.st = r_q.held ? SQ_PB_DEBOUNCE2 : SQ_IDLE;
                end else begin
                    r_d.held = 1'b1;
                end
            end
            SQ_PB_DEBOUNCE2: begin
                t_step = tick;
                if (t_done) r_d.st = SQ_IDLE;
            end
            default: r_d.st = SQ_PF_ACTIVE;
        endcase
        if (!pwr_good) r_d.st = SQ_PF_ACTIVE;
        r_d.prev = line_s;
        t_clr    = (r_d.st != r_q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= SQ_PF_ACTIVE;
            r_q.prev   <= 1'b1;
            r_q.settle <= '0;
            r_q.held   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_drive_low = (r_q.st == SQ_PF_ACTIVE) || (r_q.st == SQ_PF_HOLD) ||
                            (r_q.st == SQ_PB_DEBOUNCE1) || (r_q.st == SQ_PB_DEBOUNCE2);
    assign access_block   = line_drive_low || (r_q.st == SQ_PB_WAIT_RELEASE);
endmodule

// File: rtl/rstseq_check.sv
module rstseq_check (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic line_drive_low,
    input logic access_block
);
    assert_pf_forces_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (line_drive_low && access_block));

    assert_drive_blocks_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_drive_low |-> access_block);

    assert_release_needs_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_drive_low) |-> $past(pwr_good));

    assert_unblock_needs_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(access_block) |-> ($past(pwr_good) && !line_drive_low));
endmodule

bind rstseq_top rstseq_check u_rstseq_check (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .line_drive_low(line_drive_low), .access_block(access_block)
);

// File: tb/rstseq_top_test.sv
module rstseq_top_test;
    localparam int SYNC = 2;
    localparam int HOLD = 6;
    localparam int DEB  = 5;
    localparam int DIV  = 4;
    localparam int HOLD_MIN = DIV * (HOLD - 1);
    localparam int HOLD_MAX = DIV * HOLD + 4;
    localparam int DEB_MIN  = DIV * (DEB - 1);
    localparam int DEB_MAX  = DIV * DEB + 4;
    localparam int OSC_GAP  = 40;
    localparam int NROW = 5;
    // press length in cycles, second debounce expected
    localparam int PRESS_TAB [NROW][2] = '{'{1, 0}, '{8, 0}, '{15, 0}, '{60, 1}, '{150, 1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic tick = 1'b0;
    logic line_drive_low, access_block;
    int   cyc = 0;
    int   press_until = 0;
    int   osc_on_at = 0;
    int   checks = 0;
    int   errors = 0;
    logic button, osc_run, pad;

    assign button  = (cyc < press_until);
    assign osc_run = (cyc >= osc_on_at);
    assign pad     = !(line_drive_low || button);

    rstseq_top #(.SYNC_STAGES(SYNC), .HOLD_TICKS(HOLD), .DEB_TICKS(DEB)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .osc_run(osc_run),
        .tick(tick), .line_in(pad), .line_drive_low(line_drive_low),
        .access_block(access_block)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tick = (cyc % DIV == 0);

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic measure_low(output int len);
        len = 0;
        while (line_drive_low && len < 2000) begin
            @(negedge clk);
            len++;
        end
    endtask

    task automatic wait_drive(output int lat, input int maxc);
        lat = 0;
        while (!line_drive_low && lat < maxc) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        int len, lat, seen;
        repeat (5) @(negedge clk);
        chk(line_drive_low && access_block, "R1 reset state", {line_drive_low, access_block}, 3);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(line_drive_low && access_block, "R1 power low", {line_drive_low, access_block}, 3);

        // R2: power-up hold
        pwr_good = 1'b1;
        measure_low(len);
        chk(len >= HOLD_MIN && len <= HOLD_MAX, "R2 hold length", len, DIV * HOLD);
        chk(!access_block, "R2 access freed", access_block, 0);

        // R3: oscillator restart lengthens the hold
        pwr_good = 1'b0;
        repeat (5) @(negedge clk);
        chk(line_drive_low, "R1 power drop", line_drive_low, 1);
        osc_on_at = cyc + OSC_GAP;
        pwr_good = 1'b1;
        measure_low(len);
        chk(len >= OSC_GAP + HOLD_MIN && len <= OSC_GAP + HOLD_MAX + 2,
            "R3 hold with oscillator startup", len, OSC_GAP + DIV * HOLD);

        // pushbutton table
        for (int r = 0; r < NROW; r++) begin
            repeat (20) @(negedge clk);
            press_until = cyc + PRESS_TAB[r][0];
            wait_drive(lat, 10);
            chk(lat <= SYNC + 2, "R4 press latency", lat, SYNC + 2);
            measure_low(len);
            chk(len >= DEB_MIN && len <= DEB_MAX, "R4 first debounce", len, DIV * DEB);
            if (PRESS_TAB[r][1] == 0) begin
                seen = 0;
                for (int k = 0; k < 60; k++) begin
                    @(negedge clk);
                    if (line_drive_low) seen = 1;
                end
                chk(seen == 0 && !access_block, "R5 short press ends", {seen[0], access_block}, 0);
            end else begin
                repeat (10) @(negedge clk);
                chk(!line_drive_low && access_block, "R7 wait for release",
                    {line_drive_low, access_block}, 1);
                while (cyc < press_until) @(negedge clk);
                wait_drive(lat, 10);
                chk(line_drive_low && lat <= SYNC + 3, "R6 release latency", lat, SYNC + 3);
                measure_low(len);
                chk(len >= DEB_MIN && len <= DEB_MAX, "R6 second debounce", len, DIV * DEB);
                repeat (10) @(negedge clk);
                chk(!access_block && !line_drive_low, "R6 back to monitoring",
                    {line_drive_low, access_block}, 0);
            end
        end

        // R8: power loss in the middle of a press
        repeat (20) @(negedge clk);
        press_until = cyc + 200;
        wait_drive(lat, 10);
        repeat (5) @(negedge clk);
        pwr_good = 1'b0;
        repeat (10) @(negedge clk);
        chk(line_drive_low && access_block, "R8 forced power fail", {line_drive_low, access_block}, 3);
        while (cyc < press_until + 5) @(negedge clk);
        pwr_good = 1'b1;
        measure_low(len);
        chk(len >= HOLD_MIN && len <= HOLD_MAX, "R8 full hold after fail", len, DIV * HOLD);
        seen = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (line_drive_low || access_block) seen = 1;
        end
        chk(seen == 0, "R8 no leftover sequence", seen, 0);

        // R9: edges while driving are ignored
        pwr_good = 1'b0;
        repeat (5) @(negedge clk);
        pwr_good = 1'b1;
        repeat (3) @(negedge clk);
        press_until = cyc + 5;
        measure_low(len);
        seen = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (line_drive_low) seen = 1;
        end
        chk(seen == 0, "R9 edge during hold ignored", seen, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule